// File: doc/BRIEF.md
# Memory Port Width Down-Converter

This block sits between a wide user memory port and a narrower native memory port whose data width divides the user width exactly. Both sides have the same three channels: a command channel (valid, ready, write flag, address), a write-data channel (valid, ready, data, byte enables) and a read-data channel (valid, ready, data). Each wide user access becomes `RATIO = USER_W / NATIVE_W` narrow native accesses. Piece `i` of user address `A` goes to native address `A*RATIO + i`, and piece 0 is the least significant slice.

On a write, the user presents the command and the whole wide write word at the same time. The block issues one native write command followed by one native data beat per piece, in piece order. It acknowledges the user command only after the last beat has been accepted, and it acknowledges the write data one cycle later. On a read, the block issues `RATIO` native read commands and collects the returning narrow beats into a wide word, least significant first. It then presents that word once on the user read channel. Accesses are handled one at a time, so read words return in command order.

A single sequencer state machine drives all handshakes. Its states are:

- `ST_IDLE`: waits for a user command.
- `ST_WR_CMD`: sends a native write command for the current piece.
- `ST_WR_BEAT`: sends the matching native data beat.
- `ST_WR_CMDACK`: acknowledges the user command.
- `ST_WR_DATACK`: acknowledges the user write data.
- `ST_RD_CMD`: sends native read commands.
- `ST_RD_CMDACK`: acknowledges the user read command.
- `ST_RD_WAIT`: waits for the remaining read beats.
- `ST_RD_RESP`: presents the wide read word.

The transitions are:

- `ST_IDLE` to `ST_WR_CMD` when a write command and its data are both valid.
- `ST_IDLE` to `ST_RD_CMD` on a read command.
- `ST_WR_CMD` to `ST_WR_BEAT` when the native command is accepted.
- `ST_WR_BEAT` back to `ST_WR_CMD` on any piece but the last, or to `ST_WR_CMDACK` on the last piece.
- `ST_WR_CMDACK` to `ST_WR_DATACK`, then to `ST_IDLE`, each after one cycle.
- `ST_RD_CMD` to `ST_RD_CMDACK` once the last read command is accepted.
- `ST_RD_CMDACK` to `ST_RD_WAIT` after one cycle.
- `ST_RD_WAIT` to `ST_RD_RESP` once all beats are gathered.
- `ST_RD_RESP` to `ST_IDLE` when the user accepts the word.

A configuration whose widths do not divide is an elaboration error. So is a native width that is not a whole number of bytes.

Top module: `mem_port_narrower`

## Requirements
- R1: After reset, `n_cmd_valid`, `n_wdat_valid`, `u_rdat_valid`, `u_cmd_ready` and `u_wdat_ready` are all low.
- R2: A user write to address A produces exactly RATIO native commands with `n_cmd_we`=1, at addresses A*RATIO+0 up to A*RATIO+RATIO-1, in that order.
- R3: Native data beat i of a write carries user data bits [i*NATIVE_W +: NATIVE_W] and user byte-enable bits [i*NATIVE_W/8 +: NATIVE_W/8]. Each beat follows the accepted native command of the same piece.
- R4: For a write, `u_cmd_ready` rises only after all RATIO native data beats have been accepted, and `u_wdat_ready` is high in the cycle after the `u_cmd_ready` cycle.
- R5: A native command or data beat, once valid, stays valid with an unchanged payload until the native side accepts it, so any ready pattern stores the same memory contents.
- R6: A user read of address A produces exactly RATIO native commands with `n_cmd_we`=0, at addresses A*RATIO+0 up to A*RATIO+RATIO-1, in that order.
- R7: Returned narrow beat k fills bits [k*NATIVE_W +: NATIVE_W] of the user read word. `u_rdat_valid` rises only after all RATIO beats have arrived, and it stays high with stable data until `u_rdat_ready`.
- R8: Each user read returns exactly one wide word, holding the data most recently written at that address, and words come back in command order.
- R9: A write command presented while `u_wdat_valid` is low starts nothing: no native command is issued until the write data is valid.
- R10: With equal widths (RATIO=1), each user access maps to one native access at the same address, carrying the full data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| u_cmd_valid | input | 1 | User command valid |
| u_cmd_ready | output | 1 | User command accepted |
| u_cmd_we | input | 1 | User command is a write (1) or read (0) |
| u_cmd_addr | input | ADDR_W | User word address |
| u_wdat_valid | input | 1 | User write data valid |
| u_wdat_ready | output | 1 | User write data accepted |
| u_wdat_data | input | USER_W | User write data |
| u_wdat_be | input | USER_W/8 | User byte enables |
| u_rdat_valid | output | 1 | User read word valid |
| u_rdat_ready | input | 1 | User accepts read word |
| u_rdat_data | output | USER_W | User read word |
| n_cmd_valid | output | 1 | Native command valid |
| n_cmd_ready | input | 1 | Native command accepted |
| n_cmd_we | output | 1 | Native command is a write |
| n_cmd_addr | output | ADDR_W | Native word address |
| n_wdat_valid | output | 1 | Native write beat valid |
| n_wdat_ready | input | 1 | Native write beat accepted |
| n_wdat_data | output | NATIVE_W | Native write beat data |
| n_wdat_be | output | NATIVE_W/8 | Native write beat byte enables |
| n_rdat_valid | input | 1 | Native read beat valid |
| n_rdat_ready | output | 1 | Native read beat accepted |
| n_rdat_data | input | NATIVE_W | Native read beat data |

## Verification
The 32-to-8 configuration is swept over every user address three times. The native side is always ready, ready every other cycle, or ready one cycle in three. This tells a correct piece order and payload hold apart from beats that get lost or repeated under stalls. Each sweep is done with full byte enables and with an address-dependent sparse mask, which shows whether each enable slice reaches the right native byte. Reads follow each write sweep and are compared against a byte-level model, which exposes swapped packing lanes and stale words. A second, equal-width instance covers the passthrough case, and a write held without data checks that nothing starts early.

// File: rtl/mpn_pkg.sv
package mpn_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_CMD,
        ST_WR_BEAT,
        ST_WR_CMDACK,
        ST_WR_DATACK,
        ST_RD_CMD,
        ST_RD_CMDACK,
        ST_RD_WAIT,
        ST_RD_RESP
    } seq_state_e;

    function automatic int piece_bits(input int ratio);
        return (ratio > 1) ? $clog2(ratio) : 1;
    endfunction

endpackage

// File: rtl/mpn_lane_select.sv
module mpn_lane_select #(
    parameter int RATIO  = 2,
    parameter int LANE_W = 32,
    localparam int PW    = mpn_pkg::piece_bits(RATIO)
) (
    input  logic [RATIO*LANE_W-1:0] wide,
    input  logic [PW-1:0]           sel,
    output logic [LANE_W-1:0]       narrow
);

    logic [LANE_W-1:0] lanes [RATIO];

    for (genvar k = 0; k < RATIO; k++) begin : g_lane
        assign lanes[k] = wide[k*LANE_W +: LANE_W];
    end

    always_comb begin
        narrow = '0;
        for (int k = 0; k < RATIO; k++) begin
            if (int'(sel) == k) begin
                narrow = lanes[k];
            end
        end
    end

endmodule

// File: rtl/mpn_gather.sv
module mpn_gather #(
    parameter int RATIO  = 2,
    parameter int LANE_W = 32,
    localparam int CW    = $clog2(RATIO + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    beat_take,
    input  logic [LANE_W-1:0]       beat_data,
    output logic                    full,
    output logic [RATIO*LANE_W-1:0] wide
);

    localparam logic [CW-1:0] FULL_CNT = CW'(RATIO);

    logic [CW-1:0] cnt;

    assign full = (cnt == FULL_CNT);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (beat_take) begin
            cnt <= cnt + 1'b1;
        end
    end

    for (genvar k = 0; k < RATIO; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                wide[k*LANE_W +: LANE_W] <= '0;
            end else if (beat_take && (int'(cnt) == k)) begin
                wide[k*LANE_W +: LANE_W] <= beat_data;
            end
        end
    end

    // R7: a completed word is not disturbed until cleared
    assert_packed_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (full && !clr) |=> $stable(wide));

endmodule

// File: rtl/mpn_sequencer.sv
module mpn_sequencer
    import mpn_pkg::*;
#(
    parameter int RATIO  = 2,
    parameter int ADDR_W = 32,
    localparam int PW    = piece_bits(RATIO)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              u_cmd_valid,
    input  logic              u_cmd_we,
    input  logic [ADDR_W-1:0] u_cmd_addr,
    input  logic              u_wdat_valid,
    input  logic              u_rdat_ready,
    input  logic              n_cmd_ready,
    input  logic              n_wdat_ready,
    input  logic              gather_full,
    output logic              u_cmd_ready,
    output logic              u_wdat_ready,
    output logic              u_rdat_valid,
    output logic              n_cmd_valid,
    output logic              n_cmd_we,
    output logic [ADDR_W-1:0] n_cmd_addr,
    output logic              n_wdat_valid,
    output logic [PW-1:0]     piece,
    output logic              gather_en,
    output logic              gather_clr
);

    localparam logic [PW-1:0] LAST_P = PW'(RATIO - 1);

    seq_state_e state, state_nx;
    logic       piece_last;
    logic       piece_step;

    assign piece_last = (piece == LAST_P);
    assign piece_step = ((state == ST_WR_BEAT) && n_wdat_ready) ||
                        ((state == ST_RD_CMD) && n_cmd_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state == ST_IDLE) begin
            piece <= '0;
        end else if (piece_step) begin
            piece <= piece_last ? '0 : piece + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (u_cmd_valid) begin
                    if (!u_cmd_we) begin
                        state_nx = ST_RD_CMD;
                    end else if (u_wdat_valid) begin
                        state_nx = ST_WR_CMD;
                    end
                end
            end
            ST_WR_CMD:    if (n_cmd_ready) state_nx = ST_WR_BEAT;
            ST_WR_BEAT:   if (n_wdat_ready) state_nx = piece_last ? ST_WR_CMDACK : ST_WR_CMD;
            ST_WR_CMDACK: state_nx = ST_WR_DATACK;
            ST_WR_DATACK: state_nx = ST_IDLE;
            ST_RD_CMD:    if (n_cmd_ready && piece_last) state_nx = ST_RD_CMDACK;
            ST_RD_CMDACK: state_nx = ST_RD_WAIT;
            ST_RD_WAIT:   if (gather_full) state_nx = ST_RD_RESP;
            ST_RD_RESP:   if (u_rdat_ready) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        u_cmd_ready  = 1'b0;
        u_wdat_ready = 1'b0;
        u_rdat_valid = 1'b0;
        n_cmd_valid  = 1'b0;
        n_cmd_we     = 1'b0;
        n_wdat_valid = 1'b0;
        gather_en    = 1'b0;
        gather_clr   = 1'b0;
        unique case (state)
            ST_IDLE:      gather_clr = 1'b1;
            ST_WR_CMD:    begin n_cmd_valid = 1'b1; n_cmd_we = 1'b1; end
            ST_WR_BEAT:   n_wdat_valid = 1'b1;
            ST_WR_CMDACK: u_cmd_ready = 1'b1;
            ST_WR_DATACK: u_wdat_ready = 1'b1;
            ST_RD_CMD:    begin n_cmd_valid = 1'b1; gather_en = 1'b1; end
            ST_RD_CMDACK: begin u_cmd_ready = 1'b1; gather_en = 1'b1; end
            ST_RD_WAIT:   gather_en = 1'b1;
            ST_RD_RESP:   u_rdat_valid = 1'b1;
            default:      gather_clr = 1'b1;
        endcase
    end

    always_comb begin
        n_cmd_addr = (u_cmd_addr * ADDR_W'(RATIO)) + ADDR_W'(piece);
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(n_cmd_valid || n_wdat_valid || u_rdat_valid || u_cmd_ready || u_wdat_ready));

    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (n_cmd_valid && !n_cmd_ready) |=> (n_cmd_valid && $stable(n_cmd_addr) && $stable(n_cmd_we)));

    assert_beat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (n_wdat_valid && !n_wdat_ready) |=> (n_wdat_valid && $stable(piece)));

    assert_beat_follows_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        (n_cmd_valid && n_cmd_ready && n_cmd_we) |=> n_wdat_valid);

    assert_data_ack_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (u_cmd_ready && !gather_en) |=> u_wdat_ready);

    assert_word_complete_R7: assert property (@(posedge clk) disable iff (rst)
        u_rdat_valid |-> gather_full);

    assert_no_write_without_data_R9: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && u_cmd_valid && u_cmd_we && !u_wdat_valid) |=> !n_cmd_valid);

endmodule

// File: rtl/mem_port_narrower.sv
module mem_port_narrower #(
    parameter int USER_W   = 64,
    parameter int NATIVE_W = 32,
    parameter int ADDR_W   = 32,
    localparam int RATIO   = USER_W / NATIVE_W,
    localparam int UBE_W   = USER_W / 8,
    localparam int NBE_W   = NATIVE_W / 8,
    localparam int PW      = mpn_pkg::piece_bits(RATIO)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                u_cmd_valid,
    output logic                u_cmd_ready,
    input  logic                u_cmd_we,
    input  logic [ADDR_W-1:0]   u_cmd_addr,
    input  logic                u_wdat_valid,
    output logic                u_wdat_ready,
    input  logic [USER_W-1:0]   u_wdat_data,
    input  logic [UBE_W-1:0]    u_wdat_be,
    output logic                u_rdat_valid,
    input  logic                u_rdat_ready,
    output logic [USER_W-1:0]   u_rdat_data,
    output logic                n_cmd_valid,
    input  logic                n_cmd_ready,
    output logic                n_cmd_we,
    output logic [ADDR_W-1:0]   n_cmd_addr,
    output logic                n_wdat_valid,
    input  logic                n_wdat_ready,
    output logic [NATIVE_W-1:0] n_wdat_data,
    output logic [NBE_W-1:0]    n_wdat_be,
    input  logic                n_rdat_valid,
    output logic                n_rdat_ready,
    input  logic [NATIVE_W-1:0] n_rdat_data
);

    if ((NATIVE_W % 8 != 0) || (USER_W < NATIVE_W) || (USER_W % NATIVE_W != 0)) begin : g_bad_cfg
        $error("mem_port_narrower: user width must be a whole multiple of a byte-sized native width");
    end

    logic [PW-1:0] piece;
    logic          gather_en;
    logic          gather_clr;
    logic          gather_full;
    logic          beat_take;

    assign n_rdat_ready = gather_en && !gather_full;
    assign beat_take    = n_rdat_valid && n_rdat_ready;

    mpn_sequencer #(
        .RATIO  (RATIO),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .u_cmd_valid  (u_cmd_valid),
        .u_cmd_we     (u_cmd_we),
        .u_cmd_addr   (u_cmd_addr),
        .u_wdat_valid (u_wdat_valid),
        .u_rdat_ready (u_rdat_ready),
        .n_cmd_ready  (n_cmd_ready),
        .n_wdat_ready (n_wdat_ready),
        .gather_full  (gather_full),
        .u_cmd_ready  (u_cmd_ready),
        .u_wdat_ready (u_wdat_ready),
        .u_rdat_valid (u_rdat_valid),
        .n_cmd_valid  (n_cmd_valid),
        .n_cmd_we     (n_cmd_we),
        .n_cmd_addr   (n_cmd_addr),
        .n_wdat_valid (n_wdat_valid),
        .piece        (piece),
        .gather_en    (gather_en),
        .gather_clr   (gather_clr)
    );

    mpn_lane_select #(
        .RATIO  (RATIO),
        .LANE_W (NATIVE_W)
    ) u_data_sel (
        .wide   (u_wdat_data),
        .sel    (piece),
        .narrow (n_wdat_data)
    );

    mpn_lane_select #(
        .RATIO  (RATIO),
        .LANE_W (NBE_W)
    ) u_be_sel (
        .wide   (u_wdat_be),
        .sel    (piece),
        .narrow (n_wdat_be)
    );

    mpn_gather #(
        .RATIO  (RATIO),
        .LANE_W (NATIVE_W)
    ) u_gather (
        .clk       (clk),
        .rst       (rst),
        .clr       (gather_clr),
        .beat_take (beat_take),
        .beat_data (n_rdat_data),
        .full      (gather_full),
        .wide      (u_rdat_data)
    );

    assert_rdat_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (u_rdat_valid && !u_rdat_ready) |=> (u_rdat_valid && $stable(u_rdat_data)));

    assert_no_beat_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (n_rdat_ready |-> !u_rdat_valid));

endmodule

// File: tb/sim_mem_port_narrower.sv
`timescale 1ns/1ps

module sim_native_mem #(
    parameter int NW    = 8,
    parameter int DEPTH = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode,
    input  logic            cmd_valid,
    input  logic            cmd_we,
    input  logic [31:0]     cmd_addr,
    output logic            cmd_ready,
    input  logic            wdat_valid,
    input  logic [NW-1:0]   wdat_data,
    input  logic [NW/8-1:0] wdat_be,
    output logic            wdat_ready,
    output logic            rdat_valid,
    output logic [NW-1:0]   rdat_data,
    input  logic            rdat_ready
);
    logic [7:0]      tick = '0;
    logic            rdy;
    logic            pend_w;
    logic [31:0]     waddr;
    logic [31:0]     q [8];
    logic [3:0]      qh, qt;
    logic [NW-1:0]   mem [DEPTH];
    logic [31:0]     log_addr [64];
    logic            log_we [64];
    logic [NW-1:0]   dlog_data [64];
    logic [NW/8-1:0] dlog_be [64];
    int ln = 0;
    int dn = 0;
    int rn = 0;

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    assign rdy        = (mode == 2'd0) ? 1'b1 : (mode == 2'd1) ? tick[0] : ((int'(tick) % 3) == 0);
    assign cmd_ready  = rdy && !pend_w && ((qt - qh) < 4'd4);
    assign wdat_ready = rdy && pend_w;

    always @(posedge clk) begin
        tick <= tick + 1'b1;
        if (rst) begin
            pend_w     <= 1'b0;
            qh         <= '0;
            qt         <= '0;
            rdat_valid <= 1'b0;
            rdat_data  <= '0;
        end else begin
            if (cmd_valid && cmd_ready) begin
                log_addr[ln % 64] <= cmd_addr;
                log_we[ln % 64]   <= cmd_we;
                ln <= ln + 1;
                if (cmd_we) begin
                    pend_w <= 1'b1;
                    waddr  <= cmd_addr;
                end else begin
                    q[qt[2:0]] <= cmd_addr;
                    qt <= qt + 1'b1;
                end
            end
            if (wdat_valid && wdat_ready) begin
                for (int b = 0; b < NW/8; b++) begin
                    if (wdat_be[b]) mem[waddr % DEPTH][b*8 +: 8] <= wdat_data[b*8 +: 8];
                end
                dlog_data[dn % 64] <= wdat_data;
                dlog_be[dn % 64]   <= wdat_be;
                dn <= dn + 1;
                pend_w <= 1'b0;
            end
            if ((!rdat_valid || rdat_ready) && (qt != qh) && rdy) begin
                rdat_valid <= 1'b1;
                rdat_data  <= mem[q[qh[2:0]] % DEPTH];
                qh <= qh + 1'b1;
                rn <= rn + 1;
            end else if (rdat_ready) begin
                rdat_valid <= 1'b0;
            end
        end
    end
endmodule

module sim_mem_port_narrower;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int total = 0;
    int bad   = 0;
    logic [1:0] mode = 2'd0;

    // instance u0: 32-bit user, 8-bit native (ratio 4)
    logic        a_cv = 0, a_cr, a_cwe = 0;
    logic [31:0] a_ca = '0;
    logic        a_wv = 0, a_wr;
    logic [31:0] a_wd = '0;
    logic [3:0]  a_wb = '0;
    logic        a_rv, a_rr = 0;
    logic [31:0] a_rd;
    logic        a_ncv, a_ncr, a_ncwe, a_nwv, a_nwr, a_nrv, a_nrr;
    logic [31:0] a_nca;
    logic [7:0]  a_nwd, a_nrd;
    logic [0:0]  a_nwb;

    mem_port_narrower #(.USER_W(32), .NATIVE_W(8), .ADDR_W(32)) u0 (
        .clk(clk), .rst(rst),
        .u_cmd_valid(a_cv), .u_cmd_ready(a_cr), .u_cmd_we(a_cwe), .u_cmd_addr(a_ca),
        .u_wdat_valid(a_wv), .u_wdat_ready(a_wr), .u_wdat_data(a_wd), .u_wdat_be(a_wb),
        .u_rdat_valid(a_rv), .u_rdat_ready(a_rr), .u_rdat_data(a_rd),
        .n_cmd_valid(a_ncv), .n_cmd_ready(a_ncr), .n_cmd_we(a_ncwe), .n_cmd_addr(a_nca),
        .n_wdat_valid(a_nwv), .n_wdat_ready(a_nwr), .n_wdat_data(a_nwd), .n_wdat_be(a_nwb),
        .n_rdat_valid(a_nrv), .n_rdat_ready(a_nrr), .n_rdat_data(a_nrd));

    sim_native_mem #(.NW(8), .DEPTH(64)) m0 (
        .clk(clk), .rst(rst), .mode(mode),
        .cmd_valid(a_ncv), .cmd_we(a_ncwe), .cmd_addr(a_nca), .cmd_ready(a_ncr),
        .wdat_valid(a_nwv), .wdat_data(a_nwd), .wdat_be(a_nwb), .wdat_ready(a_nwr),
        .rdat_valid(a_nrv), .rdat_data(a_nrd), .rdat_ready(a_nrr));

    // instance u1: 16-bit to 16-bit passthrough
    logic        b_cv = 0, b_cr, b_cwe = 0;
    logic [31:0] b_ca = '0;
    logic        b_wv = 0, b_wr;
    logic [15:0] b_wd = '0;
    logic [1:0]  b_wb = '0;
    logic        b_rv, b_rr = 0;
    logic [15:0] b_rd;
    logic        b_ncv, b_ncr, b_ncwe, b_nwv, b_nwr, b_nrv, b_nrr;
    logic [31:0] b_nca;
    logic [15:0] b_nwd, b_nrd;
    logic [1:0]  b_nwb;

    mem_port_narrower #(.USER_W(16), .NATIVE_W(16), .ADDR_W(32)) u1 (
        .clk(clk), .rst(rst),
        .u_cmd_valid(b_cv), .u_cmd_ready(b_cr), .u_cmd_we(b_cwe), .u_cmd_addr(b_ca),
        .u_wdat_valid(b_wv), .u_wdat_ready(b_wr), .u_wdat_data(b_wd), .u_wdat_be(b_wb),
        .u_rdat_valid(b_rv), .u_rdat_ready(b_rr), .u_rdat_data(b_rd),
        .n_cmd_valid(b_ncv), .n_cmd_ready(b_ncr), .n_cmd_we(b_ncwe), .n_cmd_addr(b_nca),
        .n_wdat_valid(b_nwv), .n_wdat_ready(b_nwr), .n_wdat_data(b_nwd), .n_wdat_be(b_nwb),
        .n_rdat_valid(b_nrv), .n_rdat_ready(b_nrr), .n_rdat_data(b_nrd));

    sim_native_mem #(.NW(16), .DEPTH(16)) m1 (
        .clk(clk), .rst(rst), .mode(mode),
        .cmd_valid(b_ncv), .cmd_we(b_ncwe), .cmd_addr(b_nca), .cmd_ready(b_ncr),
        .wdat_valid(b_nwv), .wdat_data(b_nwd), .wdat_be(b_nwb), .wdat_ready(b_nwr),
        .rdat_valid(b_nrv), .rdat_data(b_nrd), .rdat_ready(b_nrr));

    logic [7:0] exp_mem [64];

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [31:0] pat_data(input int a, input int md, input int pass);
        logic [31:0] d;
        d = 32'h1F2E3D4C + 32'(a) * 32'h01010101 * 32'(md + 1);
        if (pass != 0) d = d ^ 32'hFFFF0000;
        return d;
    endfunction

    task automatic wr0(input int a, input logic [31:0] d, input logic [3:0] be, input int hold);
        int sl, sd;
        @(negedge clk);
        sl = m0.ln;
        sd = m0.dn;
        a_cv = 1; a_cwe = 1; a_ca = 32'(a);
        a_wd = d; a_wb = be;
        if (hold > 0) begin
            a_wv = 0;
            for (int h = 0; h < hold; h++) begin
                @(negedge clk);
                check(!a_ncv && (m0.ln == sl), "R9 no native command before write data", 64'(a_ncv), 64'd0);
            end
        end
        a_wv = 1;
        do @(negedge clk); while (!a_cr);
        check((m0.dn - sd) == 4, "R4 all beats done at command ack", 64'(m0.dn - sd), 64'd4);
        @(negedge clk);
        a_cv = 0;
        check(a_wr == 1'b1, "R4 data ack after command ack", 64'(a_wr), 64'd1);
        @(negedge clk);
        a_wv = 0;
        for (int i = 0; i < 4; i++) begin
            check(m0.log_addr[(sl + i) % 64] == 32'(a * 4 + i) && m0.log_we[(sl + i) % 64],
                  "R2 write command address", 64'(m0.log_addr[(sl + i) % 64]), 64'(a * 4 + i));
            check(m0.dlog_data[(sd + i) % 64] == d[i*8 +: 8] && m0.dlog_be[(sd + i) % 64] == be[i],
                  "R3 beat data and enable", {m0.dlog_be[(sd + i) % 64], m0.dlog_data[(sd + i) % 64]},
                  {be[i], d[i*8 +: 8]});
            if (be[i]) exp_mem[a * 4 + i] = d[i*8 +: 8];
        end
    endtask

    task automatic rd0(input int a);
        int sl, sr;
        logic [31:0] got, exp;
        @(negedge clk);
        sl = m0.ln;
        sr = m0.rn;
        a_cv = 1; a_cwe = 0; a_ca = 32'(a);
        do @(negedge clk); while (!a_cr);
        @(negedge clk);
        a_cv = 0;
        while (!a_rv) @(negedge clk);
        check((m0.rn - sr) == 4, "R7 all beats in before valid", 64'(m0.rn - sr), 64'd4);
        got = a_rd;
        @(negedge clk);
        @(negedge clk);
        check(a_rv && a_rd == got, "R7 read word held until ready", 64'(a_rd), 64'(got));
        a_rr = 1;
        @(negedge clk);
        a_rr = 0;
        check(!a_rv, "R8 one word per read", 64'(a_rv), 64'd0);
        exp = {exp_mem[a*4+3], exp_mem[a*4+2], exp_mem[a*4+1], exp_mem[a*4]};
        check(got == exp, "R7 R8 read word contents", 64'(got), 64'(exp));
        for (int i = 0; i < 4; i++) begin
            check(m0.log_addr[(sl + i) % 64] == 32'(a * 4 + i) && !m0.log_we[(sl + i) % 64],
                  "R6 read command address", 64'(m0.log_addr[(sl + i) % 64]), 64'(a * 4 + i));
        end
    endtask

    task automatic wr1(input int a, input logic [15:0] d);
        int sl, sd;
        @(negedge clk);
        sl = m1.ln;
        sd = m1.dn;
        b_cv = 1; b_cwe = 1; b_ca = 32'(a); b_wv = 1; b_wd = d; b_wb = 2'b11;
        do @(negedge clk); while (!b_cr);
        @(negedge clk);
        b_cv = 0;
        @(negedge clk);
        b_wv = 0;
        check((m1.ln - sl) == 1 && m1.log_addr[sl % 64] == 32'(a),
              "R10 single native command same address", 64'(m1.log_addr[sl % 64]), 64'(a));
        check(m1.dlog_data[sd % 64] == d, "R10 full word beat", 64'(m1.dlog_data[sd % 64]), 64'(d));
    endtask

    task automatic rd1(input int a, input logic [15:0] d);
        @(negedge clk);
        b_cv = 1; b_cwe = 0; b_ca = 32'(a);
        do @(negedge clk); while (!b_cr);
        @(negedge clk);
        b_cv = 0;
        while (!b_rv) @(negedge clk);
        check(b_rd == d, "R10 passthrough read", 64'(b_rd), 64'(d));
        b_rr = 1;
        @(negedge clk);
        b_rr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        check(!(a_ncv || a_nwv || a_rv || a_cr || a_wr), "R1 quiet in reset",
              {a_ncv, a_nwv, a_rv, a_cr, a_wr}, 64'd0);
        rst = 0;
        @(negedge clk);
        check(!(a_ncv || a_nwv || a_rv || a_cr || a_wr || b_ncv || b_rv), "R1 quiet after reset",
              {a_ncv, a_nwv, a_rv, a_cr, a_wr, b_ncv, b_rv}, 64'd0);

        wr0(5, 32'hCAFE0123, 4'hF, 4);
        rd0(5);

        for (int md = 0; md < 3; md++) begin
            mode = 2'(md);
            for (int pass = 0; pass < 2; pass++) begin
                for (int a = 0; a < 16; a++) begin
                    logic [3:0] be;
                    be = (pass == 0) ? 4'hF : (4'(a) ^ 4'(md));
                    // R5: stored contents must match under every ready pattern
                    wr0(a, pat_data(a, md, pass), be, 0);
                end
                for (int a = 0; a < 16; a++) rd0(a);
            end
        end

        mode = 2'd1;
        for (int a = 0; a < 16; a++) wr1(a, 16'(16'h3C01 + a * 16'h0107));
        for (int a = 0; a < 16; a++) rd1(a, 16'(16'h3C01 + a * 16'h0107));

        finish_run();
    end
endmodule